// File: doc/BRIEF.md
# Write Leveling Sequencer

This block is the controller-side sequencer that aligns the write strobe of one memory rank to its clock. After a start request it disables the outputs of every rank that is not being trained, switches the target rank into its leveling mode with a mode register write, waits for the mode register settling time and then enables on-die termination. After the termination settling time it parks the strobe low. After the longer of the strobe low time and the first-pulse delay, it sends single strobe pulses.

After each pulse the sequencer waits for the clock-sample feedback to travel back and settle across the data bits. It reads the feedback in one evaluation cycle. A zero moves the strobe delay tap up and a one moves it down. It then waits a configurable gap and sends the next pulse. When the feedback is zero on one evaluation and one on the next, the current tap is the aligned setting: it is locked and the sequencer leaves leveling mode with a mode register write to all ranks. If the tap hits a limit with no such edge, an error flag is raised and the sequencer exits the same way. A one-cycle done pulse follows the exit write after the settling time. The tap and the outcome flags stay valid until the next start.

States: IDLE, ENTER_OTHERS, ENTER_TARGET, WAIT_MOD, ODT_SETTLE, PARK, PULSE, WAIT_FB, EVAL, GAP, EXIT, EXIT_WAIT, DONE. Transitions:
- IDLE to ENTER_OTHERS on start.
- ENTER_OTHERS to ENTER_TARGET, and ENTER_TARGET to WAIT_MOD, unconditionally.
- WAIT_MOD to ODT_SETTLE, ODT_SETTLE to PARK and PARK to PULSE, each when its timer expires.
- PULSE to WAIT_FB unconditionally.
- WAIT_FB to EVAL when its timer expires.
- EVAL to GAP when the tap steps.
- EVAL to EXIT on lock or on a limit error.
- GAP to PULSE when its timer expires.
- EXIT to EXIT_WAIT unconditionally.
- EXIT_WAIT to DONE when its timer expires.
- DONE to IDLE unconditionally.

Top module: `wl_seq`

## Requirements
- R1: Reset state: IDLE, `cmd_o` = 0 (NOP), `mr_val_o` = 0, ODT, strobe park and pulse low, `locked_o`, `err_o`, `done_o`, `busy_o` low, `tap_o` = TAP_START.
- R2: Start is accepted only in IDLE. That edge clears `locked_o` and `err_o` and loads the tap with TAP_START. The next cycle issues `cmd_o` = 1 (write to the ranks not being trained) with `mr_val_o` = MR1_BASE with bit 7 (leveling) and bit 12 (output off) set. The cycle after that issues `cmd_o` = 2 (write to the target rank) with bit 7 set and bit 12 cleared. `mr_val_o` is 0 whenever `cmd_o` is 0.
- R3: After the target write come T_MOD cycles of NOP with ODT low. Then `odt_o` rises.
- R4: `dqs_drive_o` rises T_WLDQSEN cycles after `odt_o` rises.
- R5: The first `dqs_pulse_o` comes max(T_DQSL, T_WLMRD) cycles after the park begins. Every pulse lasts one cycle with ODT and park held high.
- R6: After each pulse, T_WLO+T_WLOE cycles pass. The next cycle is the only one in which `fb_i` is read. Its value in any other cycle has no effect.
- R7: In an evaluation without lock, feedback 0 raises `tap_o` by one and feedback 1 lowers it by one, from the next cycle. The next pulse follows after T_GAP cycles.
- R8: If feedback was 0 at the previous evaluation of a run and is 1 now, the tap is not changed and `locked_o` rises in the next cycle. Tap and `locked_o` then hold until the next accepted start.
- R9: If feedback is 0 at tap 2^TAP_W-1, or 1 at tap 0, and there is no lock, `err_o` rises instead and the tap is held.
- R10: From the target write to the exit write only NOP is issued. The exit is `cmd_o` = 3 (write to all ranks) with `mr_val_o` = MR1_BASE with bits 7 and 12 cleared. In that cycle ODT and park are low.
- R11: `done_o` is high for exactly one cycle, T_MOD+1 cycles after the exit write. The next cycle is IDLE. A start request while busy, including in the done cycle, is ignored.
- R12: A 0-to-1 edge found at the top tap locks and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, accepted in IDLE |
| fb_i | input | 1 | Clock-sample feedback from the trained rank |
| cmd_o | output | 2 | 0 NOP, 1 MR write to other ranks, 2 MR write to target rank, 3 MR write to all ranks |
| mr_val_o | output | 16 | Mode register 1 value for the write on `cmd_o` |
| odt_o | output | 1 | On-die termination enable |
| dqs_drive_o | output | 1 | Strobe parked low (complement high) |
| dqs_pulse_o | output | 1 | One-cycle request for a single strobe rising edge |
| tap_o | output | TAP_W | Strobe delay tap |
| locked_o | output | 1 | Tap locked on a 0-to-1 feedback edge |
| err_o | output | 1 | Tap limit reached without an edge |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Sequence in progress |

## Verification
Two decisions can land on the same evaluation cycle. One is the lock on a 0-to-1 edge. The other is the tap-limit check, which would either raise the error or move the tap. This is provoked by placing the feedback threshold on the top tap, so the edge is seen exactly where the limit applies, and on tap 1, so the search first turns at tap 0. It is judged by the lock flag, the error flag and the held tap in the exit write cycle. The second coincidence is a start request that lands in the done cycle or elsewhere in a run. The judgement is that the expected cycle-by-cycle trace continues unchanged and the block returns to IDLE.

// File: rtl/wl_seq_pkg.sv
package wl_seq_pkg;

    typedef enum logic [1:0] {
        CMD_NOP        = 2'd0,
        CMD_MRW_OTHERS = 2'd1,
        CMD_MRW_TARGET = 2'd2,
        CMD_MRW_ALL    = 2'd3
    } wl_cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ENTER_OTHERS,
        ST_ENTER_TARGET,
        ST_WAIT_MOD,
        ST_ODT_SETTLE,
        ST_PARK,
        ST_PULSE,
        ST_WAIT_FB,
        ST_EVAL,
        ST_GAP,
        ST_EXIT,
        ST_EXIT_WAIT,
        ST_DONE
    } wl_state_e;

    localparam int LVL_BIT  = 7;
    localparam int QOFF_BIT = 12;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wl_wait_timer.sv
module wl_wait_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/wl_tap_ctrl.sv
module wl_tap_ctrl #(
    parameter int TAP_W     = 6,
    parameter int TAP_START = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    input  logic             dec_i,
    output logic [TAP_W-1:0] tap_o,
    output logic             at_max_o,
    output logic             at_min_o
);

    localparam logic [TAP_W-1:0] TAP_TOP   = '1;
    localparam logic [TAP_W-1:0] TAP_RESET = TAP_W'(TAP_START);

    logic [TAP_W-1:0] tap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap_q <= TAP_RESET;
        end else if (clr_i) begin
            tap_q <= TAP_RESET;
        end else if (inc_i && (tap_q != TAP_TOP)) begin
            tap_q <= tap_q + 1'b1;
        end else if (dec_i && (tap_q != '0)) begin
            tap_q <= tap_q - 1'b1;
        end
    end

    assign tap_o    = tap_q;
    assign at_max_o = (tap_q == TAP_TOP);
    assign at_min_o = (tap_q == '0);

endmodule

// File: rtl/wl_fb_track.sv
module wl_fb_track (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic sample_i,
    input  logic fb_i,
    output logic rise_o
);

    logic have_q;
    logic prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_q <= 1'b0;
            prev_q <= 1'b0;
        end else if (clr_i) begin
            have_q <= 1'b0;
            prev_q <= 1'b0;
        end else if (sample_i) begin
            have_q <= 1'b1;
            prev_q <= fb_i;
        end
    end

    assign rise_o = sample_i && have_q && !prev_q && fb_i;

endmodule

// File: rtl/wl_seq.sv
module wl_seq
    import wl_seq_pkg::*;
#(
    parameter int          TAP_W     = 6,
    parameter int          TAP_START = 32,
    parameter int          T_MOD     = 12,
    parameter int          T_WLDQSEN = 25,
    parameter int          T_DQSL    = 2,
    parameter int          T_WLMRD   = 40,
    parameter int          T_WLO     = 7,
    parameter int          T_WLOE    = 2,
    parameter int          T_GAP     = 4,
    parameter logic [15:0] MR1_BASE  = 16'h0046
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             fb_i,
    output logic [1:0]       cmd_o,
    output logic [15:0]      mr_val_o,
    output logic             odt_o,
    output logic             dqs_drive_o,
    output logic             dqs_pulse_o,
    output logic [TAP_W-1:0] tap_o,
    output logic             locked_o,
    output logic             err_o,
    output logic             done_o,
    output logic             busy_o
);

    localparam int          T_PARK   = max2(T_DQSL, T_WLMRD);
    localparam int          T_FB     = T_WLO + T_WLOE;
    localparam int          MAX_WAIT = max2(max2(max2(T_MOD, T_WLDQSEN), max2(T_PARK, T_FB)), T_GAP);
    localparam int          CNT_W    = $clog2(MAX_WAIT + 1);
    localparam logic [15:0] LVL_M    = 16'h0001 << LVL_BIT;
    localparam logic [15:0] QOFF_M   = 16'h0001 << QOFF_BIT;
    localparam logic [15:0] BASE_CLR = MR1_BASE & ~(LVL_M | QOFF_M);

    wl_state_e        state_q;
    wl_state_e        state_d;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_exp;
    logic             start_acc;
    logic             in_eval;
    logic             fb_rise;
    logic             at_max;
    logic             at_min;
    logic             step_up;
    logic             step_dn;
    logic             lim_err;
    logic             finish;
    logic             locked_q;
    logic             err_q;
    wl_cmd_e          cmd_sel;

    assign start_acc = (state_q == ST_IDLE) && start_i;
    assign in_eval   = (state_q == ST_EVAL);
    assign lim_err   = in_eval && !fb_rise && ((!fb_i && at_max) || (fb_i && at_min));
    assign step_up   = in_eval && !fb_rise && !fb_i && !at_max;
    assign step_dn   = in_eval && !fb_rise && fb_i && !at_min;
    assign finish    = fb_rise || lim_err;

    wl_wait_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .load_val_i(tmr_val),
        .expired_o (tmr_exp)
    );

    wl_tap_ctrl #(
        .TAP_W    (TAP_W),
        .TAP_START(TAP_START)
    ) u_tap (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (start_acc),
        .inc_i   (step_up),
        .dec_i   (step_dn),
        .tap_o   (tap_o),
        .at_max_o(at_max),
        .at_min_o(at_min)
    );

    wl_fb_track u_fb (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (start_acc),
        .sample_i(in_eval),
        .fb_i    (fb_i),
        .rise_o  (fb_rise)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:         if (start_i) state_d = ST_ENTER_OTHERS;
            ST_ENTER_OTHERS: state_d = ST_ENTER_TARGET;
            ST_ENTER_TARGET: state_d = ST_WAIT_MOD;
            ST_WAIT_MOD:     if (tmr_exp) state_d = ST_ODT_SETTLE;
            ST_ODT_SETTLE:   if (tmr_exp) state_d = ST_PARK;
            ST_PARK:         if (tmr_exp) state_d = ST_PULSE;
            ST_PULSE:        state_d = ST_WAIT_FB;
            ST_WAIT_FB:      if (tmr_exp) state_d = ST_EVAL;
            ST_EVAL:         state_d = finish ? ST_EXIT : ST_GAP;
            ST_GAP:          if (tmr_exp) state_d = ST_PULSE;
            ST_EXIT:         state_d = ST_EXIT_WAIT;
            ST_EXIT_WAIT:    if (tmr_exp) state_d = ST_DONE;
            ST_DONE:         state_d = ST_IDLE;
            default:         state_d = ST_IDLE;
        endcase
    end

    // wait length for the state being entered
    always_comb begin
        tmr_load = (state_d != state_q);
        tmr_val  = '0;
        unique case (state_d)
            ST_WAIT_MOD:   tmr_val = CNT_W'(T_MOD - 1);
            ST_ODT_SETTLE: tmr_val = CNT_W'(T_WLDQSEN - 1);
            ST_PARK:       tmr_val = CNT_W'(T_PARK - 1);
            ST_WAIT_FB:    tmr_val = CNT_W'(T_FB - 1);
            ST_GAP:        tmr_val = CNT_W'(T_GAP - 1);
            ST_EXIT_WAIT:  tmr_val = CNT_W'(T_MOD - 1);
            default:       tmr_val = '0;
        endcase
    end

    // outcome flags, held until the next accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_q <= 1'b0;
            err_q    <= 1'b0;
        end else if (start_acc) begin
            locked_q <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            if (fb_rise) locked_q <= 1'b1;
            if (lim_err) err_q    <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        cmd_sel     = CMD_NOP;
        mr_val_o    = '0;
        odt_o       = 1'b0;
        dqs_drive_o = 1'b0;
        dqs_pulse_o = 1'b0;
        done_o      = 1'b0;
        busy_o      = 1'b1;
        unique case (state_q)
            ST_IDLE: busy_o = 1'b0;
            ST_ENTER_OTHERS: begin
                cmd_sel  = CMD_MRW_OTHERS;
                mr_val_o = BASE_CLR | LVL_M | QOFF_M;
            end
            ST_ENTER_TARGET: begin
                cmd_sel  = CMD_MRW_TARGET;
                mr_val_o = BASE_CLR | LVL_M;
            end
            ST_WAIT_MOD:   ;
            ST_ODT_SETTLE: odt_o = 1'b1;
            ST_PARK, ST_WAIT_FB, ST_EVAL, ST_GAP: begin
                odt_o       = 1'b1;
                dqs_drive_o = 1'b1;
            end
            ST_PULSE: begin
                odt_o       = 1'b1;
                dqs_drive_o = 1'b1;
                dqs_pulse_o = 1'b1;
            end
            ST_EXIT: begin
                cmd_sel  = CMD_MRW_ALL;
                mr_val_o = BASE_CLR;
            end
            ST_EXIT_WAIT: ;
            ST_DONE:      done_o = 1'b1;
            default:      busy_o = 1'b0;
        endcase
    end

    assign cmd_o    = cmd_sel;
    assign locked_o = locked_q;
    assign err_o    = err_q;

endmodule

// File: rtl/wl_seq_chk.sv
module wl_seq_chk #(
    parameter int TAP_W  = 6,
    parameter int T_MOD  = 12,
    parameter int T_ODT  = 25,
    parameter int T_PARK = 40
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       cmd_o,
    input logic             odt_o,
    input logic             dqs_drive_o,
    input logic             dqs_pulse_o,
    input logic [TAP_W-1:0] tap_o,
    input logic             locked_o,
    input logic             err_o,
    input logic             done_o,
    input logic             busy_o
);

    localparam int SAT = 1 << 20;

    int mrw_age;
    int odt_age;
    int drv_age;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mrw_age <= 0;
            odt_age <= 0;
            drv_age <= 0;
        end else begin
            if (cmd_o == 2'd2)     mrw_age <= 1;
            else if (mrw_age < SAT) mrw_age <= mrw_age + 1;
            if (!odt_o)             odt_age <= 0;
            else if (odt_age < SAT) odt_age <= odt_age + 1;
            if (!dqs_drive_o)       drv_age <= 0;
            else if (drv_age < SAT) drv_age <= drv_age + 1;
        end
    end

    assert_odt_after_mod_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(odt_o) |-> (mrw_age > T_MOD));

    assert_park_after_odt_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dqs_drive_o) |-> (odt_age >= T_ODT));

    assert_pulse_after_park_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dqs_pulse_o |-> (drv_age >= T_PARK) && odt_o);

    assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dqs_pulse_o |=> !dqs_pulse_o);

    assert_tap_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && (tap_o != $past(tap_o)))
        |-> ((int'(tap_o) == int'($past(tap_o)) + 1) || (int'(tap_o) + 1 == int'($past(tap_o)))));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !$past(busy_o)) |-> ($stable(tap_o) && $stable(locked_o) && $stable(err_o)));

    assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(locked_o && err_o));

    assert_nop_during_search_R10: assert property (@(posedge clk) disable iff (!rst_n)
        odt_o |-> (cmd_o == 2'd0));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    assert_done_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (locked_o || err_o));

endmodule

bind wl_seq wl_seq_chk #(
    .TAP_W (TAP_W),
    .T_MOD (T_MOD),
    .T_ODT (T_WLDQSEN),
    .T_PARK((T_DQSL > T_WLMRD) ? T_DQSL : T_WLMRD)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_o      (cmd_o),
    .odt_o      (odt_o),
    .dqs_drive_o(dqs_drive_o),
    .dqs_pulse_o(dqs_pulse_o),
    .tap_o      (tap_o),
    .locked_o   (locked_o),
    .err_o      (err_o),
    .done_o     (done_o),
    .busy_o     (busy_o)
);

// File: tb/wl_seq_test.sv
module wl_seq_test;

    localparam int          CLK_PERIOD = 10;
    localparam int          TAP_W      = 6;
    localparam int          TAP_START  = 32;
    localparam int          TAP_TOP    = (1 << TAP_W) - 1;
    localparam int          T_MOD      = 12;
    localparam int          T_WLDQSEN  = 25;
    localparam int          T_DQSL     = 2;
    localparam int          T_WLMRD    = 40;
    localparam int          T_WLO      = 7;
    localparam int          T_WLOE     = 2;
    localparam int          T_GAP      = 4;
    localparam logic [15:0] MR1_BASE   = 16'h10C6;
    localparam int          T_PARK     = (T_DQSL > T_WLMRD) ? T_DQSL : T_WLMRD;
    localparam int          T_FB       = T_WLO + T_WLOE;
    localparam logic [15:0] MR_CLEAN   = MR1_BASE & ~16'h1080;

    typedef struct packed {
        logic             busy;
        logic             done;
        logic             err;
        logic             locked;
        logic             pulse;
        logic             drive;
        logic             odt;
        logic [1:0]       cmd;
        logic [15:0]      mr;
        logic [TAP_W-1:0] tap;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             fb_i = 1'b0;
    logic [1:0]       cmd_o;
    logic [15:0]      mr_val_o;
    logic             odt_o;
    logic             dqs_drive_o;
    logic             dqs_pulse_o;
    logic [TAP_W-1:0] tap_o;
    logic             locked_o;
    logic             err_o;
    logic             done_o;
    logic             busy_o;

    int    checks = 0;
    int    failures = 0;
    bit    finished = 0;
    int    m_tap = TAP_START;
    bit    m_locked = 0;
    bit    m_err = 0;
    int    thr_cur = 0;
    string idle_tag = "R1";
    exp_t  q_exp[$];
    string q_tag[$];
    int    q_fb[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    wl_seq #(
        .TAP_W(TAP_W), .TAP_START(TAP_START), .T_MOD(T_MOD), .T_WLDQSEN(T_WLDQSEN),
        .T_DQSL(T_DQSL), .T_WLMRD(T_WLMRD), .T_WLO(T_WLO), .T_WLOE(T_WLOE),
        .T_GAP(T_GAP), .MR1_BASE(MR1_BASE)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .fb_i(fb_i),
        .cmd_o(cmd_o), .mr_val_o(mr_val_o), .odt_o(odt_o), .dqs_drive_o(dqs_drive_o),
        .dqs_pulse_o(dqs_pulse_o), .tap_o(tap_o), .locked_o(locked_o), .err_o(err_o),
        .done_o(done_o), .busy_o(busy_o)
    );

    function automatic exp_t make(bit busy, bit done, bit odt, bit drv, bit pls, int cmd, logic [15:0] mr);
        exp_t e;
        e.busy = busy; e.done = done; e.err = m_err; e.locked = m_locked;
        e.pulse = pls; e.drive = drv; e.odt = odt; e.cmd = 2'(cmd); e.mr = mr;
        e.tap = TAP_W'(m_tap);
        return e;
    endfunction

    task automatic push(bit busy, bit done, bit odt, bit drv, bit pls, int cmd,
                        logic [15:0] mr, string tag, int fbv);
        q_exp.push_back(make(busy, done, odt, drv, pls, cmd, mr));
        q_tag.push_back(tag);
        q_fb.push_back(fbv);
    endtask

    // behavioural schedule of one whole run, one entry per cycle after the start edge
    task automatic plan_run(int thr);
        int    prev = -1;
        int    fb;
        string outcome;
        m_locked = 0; m_err = 0; m_tap = TAP_START;
        push(1, 0, 0, 0, 0, 1, MR_CLEAN | 16'h1080, "R2", -1);
        push(1, 0, 0, 0, 0, 2, MR_CLEAN | 16'h0080, "R2", -1);
        for (int i = 0; i < T_MOD; i++)     push(1, 0, 0, 0, 0, 0, 16'h0, "R3", -1);
        for (int i = 0; i < T_WLDQSEN; i++) push(1, 0, 1, 0, 0, 0, 16'h0, "R4", -1);
        for (int i = 0; i < T_PARK; i++)    push(1, 0, 1, 1, 0, 0, 16'h0, "R5", -1);
        forever begin
            push(1, 0, 1, 1, 1, 0, 16'h0, "R5", -1);
            for (int i = 0; i < T_FB; i++) push(1, 0, 1, 1, 0, 0, 16'h0, "R6", -1);
            fb = (m_tap >= thr) ? 1 : 0;
            push(1, 0, 1, 1, 0, 0, 16'h0, "R6", fb);
            if (prev == 0 && fb == 1) begin
                m_locked = 1;
                outcome = (m_tap == TAP_TOP) ? "R12" : "R8";
                break;
            end else if (fb == 0) begin
                if (m_tap == TAP_TOP) begin m_err = 1; outcome = "R9"; break; end
                m_tap++;
            end else begin
                if (m_tap == 0) begin m_err = 1; outcome = "R9"; break; end
                m_tap--;
            end
            prev = fb;
            for (int i = 0; i < T_GAP; i++) push(1, 0, 1, 1, 0, 0, 16'h0, "R7", -1);
        end
        push(1, 0, 0, 0, 0, 3, MR_CLEAN, (outcome == "R8") ? "R10" : outcome, -1);
        for (int i = 0; i < T_MOD; i++) push(1, 0, 0, 0, 0, 0, 16'h0, "R11", -1);
        push(1, 1, 0, 0, 0, 0, 16'h0, "R11", -1);
        push(0, 0, 0, 0, 0, 0, 16'h0, "R11", -1);
    endtask

    task automatic compare(exp_t e, string tag);
        exp_t a;
        a.busy = busy_o; a.done = done_o; a.err = err_o; a.locked = locked_o;
        a.pulse = dqs_pulse_o; a.drive = dqs_drive_o; a.odt = odt_o; a.cmd = cmd_o;
        a.mr = mr_val_o; a.tap = tap_o;
        checks++;
        if (a !== e) begin
            failures++;
            $display("FAIL %s t=%0t actual=%h expected=%h (busy done err lock pulse drive odt cmd mr tap)",
                     tag, $time, a, e);
        end
    endtask

    task automatic step(bit want_new, bit poke);
        exp_t  e;
        string tag;
        int    fbv;
        @(negedge clk);
        if (q_exp.size() > 0) begin
            e = q_exp.pop_front(); tag = q_tag.pop_front(); fbv = q_fb.pop_front();
        end else begin
            e = make(0, 0, 0, 0, 0, 0, 16'h0); tag = idle_tag; fbv = -1;
        end
        compare(e, tag);
        // R6: outside the evaluation cycle feedback is noise
        fb_i = (fbv < 0) ? 1'($urandom_range(0, 1)) : (fbv == 1);
        start_i = 1'b0;
        if (q_exp.size() == 0) begin
            if (want_new) begin
                plan_run(thr_cur);
                start_i = 1'b1;
            end
        end else if (poke) begin
            start_i = ($urandom_range(0, 3) == 0); // R11: ignored while busy
        end
    endtask

    task automatic run(int thr, bit poke);
        thr_cur = thr;
        step(1, 0);
        while (q_exp.size() > 0) step(0, poke);
        idle_tag = "R8";
        for (int i = 0; i < 4; i++) step(0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) step(0, 0);   // R1
        run(40, 0);        // climb to edge, R7 R8
        run(20, 1);        // descend then lock, with ignored starts R11
        run(1, 0);         // turn at tap 0 then lock at 1
        run(0, 0);         // all ones: error at tap 0, R9
        run(TAP_TOP + 1, 1); // all zeros: error at top tap, R9
        run(TAP_TOP, 0);   // edge on the top tap, R12
        run(45, 1);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule